// File: doc/BRIEF.md
# NAND ECC Status Scanner

This block runs after a full-page read has landed in one of the controller's page buffers. It turns the hardware ECC engine's per-sector results into a page verdict. From the page number and the page-size configuration it works out which buffer the page occupies and which 512-byte sectors belong to that buffer. It then fetches each sector's 4-bit error count from a small bank of packed 32-bit status words. Counts from 0 to 14 are added into a saturating corrected-error total. A count of 15 marks the sector as uncorrectable and ends the status walk.

An uncorrectable code does not become an error on its own. An erased page carries no valid ECC, so the decoder flags it even though nothing is wrong. The block therefore reads back the buffer's main area and the ECC bytes in its spare area. It raises the uncorrectable flag only when some word in that region is not all ones. Both memory ports have a fixed read latency of one cycle.

Software or a sequencer pulses `start` and waits for the one-cycle `done` pulse. After that, `corr_total` and `uncorr` stay valid until the next accepted start.

Top module: `nand_ecc_scan`

## Requirements
- R1: After reset, `done`, `uncorr` and `corr_total` are all zero.
- R2: The buffer index is the low four bits of `page_num` masked with 15, 3 or 1, for `page_cfg` 0 (512-byte page), 1 (2 KiB) or 2 (4 KiB). Code 3 behaves as 4 KiB. The sectors examined run from index×steps to index×steps+steps−1, with steps 1, 4 or 8. No status word outside that range is read.
- R3: The count of sector n is taken from status word n/4, bits [(3−n mod 4)×8+3 : (3−n mod 4)×8]. The upper four bits of each status byte are ignored.
- R4: Every count from 0 to 14 in the examined range is added into `corr_total`.
- R5: `corr_total` saturates at 2^CNT_W−1 and never wraps.
- R6: The status walk stops at the first sector whose count is 15. Later sectors are not read, and earlier counts stay in the total.
- R7: After a count of 15, `uncorr` is set unless the buffer reads as erased. The buffer starts at word index×(page bytes/2). Its main area is page bytes/4 words. Its ECC region starts 2 words after the main area and is steps×2 words long (`wide_ecc`=0) or steps×4 words long (`wide_ecc`=1). Erased means every word of both regions reads 0xFFFFFFFF.
- R8: When the buffer reads as erased, `uncorr` stays 0 and the total keeps the counts summed before the code 15.
- R9: Spare-area words outside the ECC region have no effect on the verdict.
- R10: The erased-check stops reading at the first word that is not all ones.
- R11: `done` is high for exactly one cycle. The results hold until the next accepted `start`, which clears them.
- R12: A `start` pulse that arrives while a scan is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan (accepted when idle) |
| page_num | input | PAGE_W | Page number of the completed read |
| page_cfg | input | 2 | Page size code: 0=512 B, 1=2 KiB, 2/3=4 KiB |
| wide_ecc | input | 1 | 1 selects 16 ECC bytes per sector, 0 selects 8 |
| stat_rd | output | 1 | Status word read strobe |
| stat_addr | output | 2 | Status word index |
| stat_rdata | input | 32 | Status word, valid the cycle after `stat_rd` |
| mem_rd | output | 1 | Page buffer read strobe |
| mem_addr | output | MEM_AW | Page buffer word address |
| mem_rdata | input | 32 | Page buffer word, valid the cycle after `mem_rd` |
| done | output | 1 | One-cycle completion pulse |
| corr_total | output | CNT_W | Saturating corrected-error total |
| uncorr | output | 1 | Page has an uncorrectable, non-erased sector |

## Verification
The bench builds the block with CNT_W=6 and keeps the default PAGE_W=16 and MEM_AW=12. The 6-bit total makes saturation reachable: eight 4 KiB sectors each reporting 14 add up to 112, well past 63. The 12-bit word address covers the whole 16 KiB buffer area. This lets the bench place erased and dirty words at the exact ends of the main area and the narrow and wide ECC regions, and count the memory reads each case needs.

// File: rtl/nand_ecc_scan_pkg.sv
// Shared constants and types for the ECC status scanner.
// Assumes a fixed arrangement of 16 sectors spread over all page buffers.
package nand_ecc_scan_pkg;

    localparam int SECT_TOTAL = 16;
    localparam int SEC_W      = $clog2(SECT_TOTAL);
    localparam int STAT_WORDS = SECT_TOTAL / 4;
    localparam int SW_AW      = $clog2(STAT_WORDS);

    localparam logic [3:0] CNT_UNCORR = 4'hF;
    localparam logic [31:0] WORD_ERASED = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        PG_512    = 2'd0,
        PG_2K     = 2'd1,
        PG_4K     = 2'd2,
        PG_4K_ALT = 2'd3
    } pg_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_REQ,
        ST_USE,
        ST_BLANK
    } scan_state_e;

    typedef enum logic [1:0] {
        BL_IDLE,
        BL_ISSUE,
        BL_CHECK
    } blank_state_e;

endpackage

// File: rtl/nand_ecc_geom.sv
// Geometry decoder: maps page number and size code to the buffer's sector
// range and to the word regions the erased-check must read.
// Assumes 512-byte sectors and buffers of twice the page size, packed back to back.
module nand_ecc_geom
    import nand_ecc_scan_pkg::*;
#(
    parameter int PAGE_W = 16,
    parameter int MEM_AW = 12
) (
    input  logic [PAGE_W-1:0] page_num,
    input  logic [1:0]        pg_code,
    input  logic              wide_ecc,
    output logic [SEC_W-1:0]  first_sec,
    output logic [SEC_W-1:0]  last_sec,
    output logic [MEM_AW-1:0] main_base,
    output logic [MEM_AW-1:0] main_words,
    output logic [MEM_AW-1:0] ecc_base,
    output logic [MEM_AW-1:0] ecc_words
);

    logic [3:0] buf_idx;
    logic [1:0] steps_log;
    logic [3:0] words_log;

    // Per-size mask, sectors-per-page and main-area size (both as log2).
    always_comb begin
        case (pg_size_e'(pg_code))
            PG_512: begin
                buf_idx   = page_num[3:0];
                steps_log = 2'd0;
                words_log = 4'd7;
            end
            PG_2K: begin
                buf_idx   = page_num[3:0] & 4'd3;
                steps_log = 2'd2;
                words_log = 4'd9;
            end
            default: begin
                buf_idx   = page_num[3:0] & 4'd1;
                steps_log = 2'd3;
                words_log = 4'd10;
            end
        endcase
    end

    // Sector range and word regions derived from the decoded geometry.
    always_comb begin
        first_sec  = SEC_W'(buf_idx << steps_log);
        last_sec   = first_sec + SEC_W'((4'd1 << steps_log) - 4'd1);
        main_words = MEM_AW'(1) << words_log;
        main_base  = MEM_AW'(buf_idx) << (words_log + 4'd1);
        ecc_base   = main_base + main_words + MEM_AW'(2);
        ecc_words  = MEM_AW'(1) << ({2'b00, steps_log} + (wide_ecc ? 4'd2 : 4'd1));
    end

endmodule

// File: rtl/nand_ecc_nibble.sv
// Count picker: selects a sector's 4-bit error count from a packed status
// word. Sector lane 0 sits in the most significant byte (big-endian packing).
module nand_ecc_nibble (
    input  logic [31:0] word,
    input  logic [1:0]  lane,
    output logic [3:0]  cnt
);

    // Low nibble of the byte chosen by the lane, counting from the top.
    always_comb begin
        case (lane)
            2'd0:    cnt = word[27:24];
            2'd1:    cnt = word[19:16];
            2'd2:    cnt = word[11:8];
            default: cnt = word[3:0];
        endcase
    end

endmodule

// File: rtl/nand_ecc_blank.sv
// Erased-page checker: reads the main area and then the ECC region word by
// word, and stops at the first word that is not all ones.
// Assumes a one-cycle read latency and region bases/lengths that stay stable
// while it runs. Each region has at least one word.
module nand_ecc_blank
    import nand_ecc_scan_pkg::*;
#(
    parameter int MEM_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [MEM_AW-1:0] main_base,
    input  logic [MEM_AW-1:0] main_words,
    input  logic [MEM_AW-1:0] ecc_base,
    input  logic [MEM_AW-1:0] ecc_words,
    output logic              mem_rd,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic [31:0]       mem_rdata,
    output logic              fin,
    output logic              erased
);

    blank_state_e      state;
    logic [MEM_AW-1:0] cur_addr;
    logic [MEM_AW-1:0] remain;
    logic              in_ecc;

    // Walk both regions; report on the first dirty word or after the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= BL_IDLE;
            cur_addr <= '0;
            remain   <= '0;
            in_ecc   <= 1'b0;
            fin      <= 1'b0;
            erased   <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (state)
                BL_IDLE: begin
                    if (go) begin
                        cur_addr <= main_base;
                        remain   <= main_words;
                        in_ecc   <= 1'b0;
                        state    <= BL_ISSUE;
                    end
                end
                BL_ISSUE: state <= BL_CHECK;
                BL_CHECK: begin
                    if (mem_rdata != WORD_ERASED) begin
                        fin    <= 1'b1;
                        erased <= 1'b0;
                        state  <= BL_IDLE;
                    end else if (remain == MEM_AW'(1)) begin
                        if (!in_ecc) begin
                            cur_addr <= ecc_base;
                            remain   <= ecc_words;
                            in_ecc   <= 1'b1;
                            state    <= BL_ISSUE;
                        end else begin
                            fin    <= 1'b1;
                            erased <= 1'b1;
                            state  <= BL_IDLE;
                        end
                    end else begin
                        cur_addr <= cur_addr + MEM_AW'(1);
                        remain   <= remain - MEM_AW'(1);
                        state    <= BL_ISSUE;
                    end
                end
                default: state <= BL_IDLE;
            endcase
        end
    end

    // Read strobe in the issue cycle only.
    always_comb begin
        mem_rd   = (state == BL_ISSUE);
        mem_addr = cur_addr;
    end

endmodule

// File: rtl/nand_ecc_scan.sv
// ECC status scanner top: walks the status counts of one page buffer,
// accumulates the corrected total and, on a count of 15, runs the erased-check
// before flagging the page as uncorrectable.
// Assumes both read ports return data exactly one cycle after the strobe.
module nand_ecc_scan
    import nand_ecc_scan_pkg::*;
#(
    parameter int PAGE_W = 16,
    parameter int CNT_W  = 10,
    parameter int MEM_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PAGE_W-1:0] page_num,
    input  logic [1:0]        page_cfg,
    input  logic              wide_ecc,
    output logic              stat_rd,
    output logic [SW_AW-1:0]  stat_addr,
    input  logic [31:0]       stat_rdata,
    output logic              mem_rd,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic [31:0]       mem_rdata,
    output logic              done,
    output logic [CNT_W-1:0]  corr_total,
    output logic              uncorr
);

    scan_state_e       state;
    logic [PAGE_W-1:0] page_q;
    logic [1:0]        cfg_q;
    logic              wide_q;
    logic [SEC_W-1:0]  sec_cur;
    logic [SEC_W-1:0]  first_sec;
    logic [SEC_W-1:0]  last_sec;
    logic [MEM_AW-1:0] main_base;
    logic [MEM_AW-1:0] main_words;
    logic [MEM_AW-1:0] ecc_base;
    logic [MEM_AW-1:0] ecc_words;
    logic [3:0]        cnt;
    logic [CNT_W:0]    sum;
    logic              blank_go;
    logic              blank_fin;
    logic              blank_erased;
    logic              busy;

    nand_ecc_geom #(
        .PAGE_W (PAGE_W),
        .MEM_AW (MEM_AW)
    ) geom_i (
        .page_num   (page_q),
        .pg_code    (cfg_q),
        .wide_ecc   (wide_q),
        .first_sec  (first_sec),
        .last_sec   (last_sec),
        .main_base  (main_base),
        .main_words (main_words),
        .ecc_base   (ecc_base),
        .ecc_words  (ecc_words)
    );

    nand_ecc_nibble pick_i (
        .word (stat_rdata),
        .lane (sec_cur[1:0]),
        .cnt  (cnt)
    );

    nand_ecc_blank #(
        .MEM_AW (MEM_AW)
    ) blank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (blank_go),
        .main_base  (main_base),
        .main_words (main_words),
        .ecc_base   (ecc_base),
        .ecc_words  (ecc_words),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .fin        (blank_fin),
        .erased     (blank_erased)
    );

    // Status strobe, erased-check trigger and running sum.
    always_comb begin
        busy      = (state != ST_IDLE);
        stat_rd   = (state == ST_REQ);
        stat_addr = sec_cur[SEC_W-1:2];
        blank_go  = (state == ST_USE) && (cnt == CNT_UNCORR);
        sum       = {1'b0, corr_total} + (CNT_W+1)'(cnt);
    end

    // Scan sequencer: latch the request, fetch each count, decide and finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            page_q     <= '0;
            cfg_q      <= '0;
            wide_q     <= 1'b0;
            sec_cur    <= '0;
            corr_total <= '0;
            uncorr     <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        page_q     <= page_num;
                        cfg_q      <= page_cfg;
                        wide_q     <= wide_ecc;
                        corr_total <= '0;
                        uncorr     <= 1'b0;
                        state      <= ST_PREP;
                    end
                end
                ST_PREP: begin
                    sec_cur <= first_sec;
                    state   <= ST_REQ;
                end
                ST_REQ: state <= ST_USE;
                ST_USE: begin
                    if (cnt == CNT_UNCORR) begin
                        state <= ST_BLANK;
                    end else begin
                        corr_total <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
                        if (sec_cur == last_sec) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            sec_cur <= sec_cur + SEC_W'(1);
                            state   <= ST_REQ;
                        end
                    end
                end
                ST_BLANK: begin
                    if (blank_fin) begin
                        uncorr <= !blank_erased;
                        done   <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nand_ecc_scan_chk.sv
// Property checker for the ECC status scanner, bound to the top module.
module nand_ecc_scan_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             uncorr,
    input logic             stat_rd,
    input logic             mem_rd,
    input logic [CNT_W-1:0] corr_total
);

    // R11: completion is a single-cycle pulse.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: an accepted start clears both results.
    p_clear_on_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (corr_total == '0) && !uncorr);

    // R11: results hold while idle and no start arrives.
    p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(corr_total) && $stable(uncorr)));

    // R5: during a scan the total only grows or stays (saturates, never wraps).
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (corr_total >= $past(corr_total)));

    // R6: the status walk has ended before any buffer read happens.
    p_ports_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_rd && mem_rd));

    // R7: the uncorrectable flag only rises together with completion.
    p_flag_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uncorr) |-> done);

endmodule

bind nand_ecc_scan nand_ecc_scan_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .uncorr     (uncorr),
    .stat_rd    (stat_rd),
    .mem_rd     (mem_rd),
    .corr_total (corr_total)
);

// File: tb/nand_ecc_scan_tb_top.sv
// Directed bench for the ECC status scanner: one task per scenario.
module nand_ecc_scan_tb_top;

    localparam int PAGE_W = 16;
    localparam int CNT_W  = 6;
    localparam int MEM_AW = 12;
    localparam int MEM_WORDS = 1 << MEM_AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [PAGE_W-1:0] page_num = '0;
    logic [1:0]        page_cfg = 2'd0;
    logic              wide_ecc = 1'b0;
    logic              stat_rd;
    logic [1:0]        stat_addr;
    logic [31:0]       stat_rdata = '0;
    logic              mem_rd;
    logic [MEM_AW-1:0] mem_addr;
    logic [31:0]       mem_rdata = '0;
    logic              done;
    logic [CNT_W-1:0]  corr_total;
    logic              uncorr;

    logic [31:0] mem  [0:MEM_WORDS-1];
    logic [31:0] stat [0:3];

    int n_checks = 0;
    int n_fail   = 0;
    int mem_reads  = 0;
    int stat_reads = 0;

    int got_total;
    int got_unc;
    int got_mreads;
    int got_sreads;

    always #2 clk = ~clk;

    nand_ecc_scan #(
        .PAGE_W (PAGE_W),
        .CNT_W  (CNT_W),
        .MEM_AW (MEM_AW)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .page_num   (page_num),
        .page_cfg   (page_cfg),
        .wide_ecc   (wide_ecc),
        .stat_rd    (stat_rd),
        .stat_addr  (stat_addr),
        .stat_rdata (stat_rdata),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .done       (done),
        .corr_total (corr_total),
        .uncorr     (uncorr)
    );

    // Memories with one cycle of read latency, plus read counters.
    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr];
            mem_reads <= mem_reads + 1;
        end
        if (stat_rd) begin
            stat_rdata <= stat[stat_addr];
            stat_reads <= stat_reads + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic stat_all_uncorr();
        for (int i = 0; i < 4; i++) stat[i] = 32'hFFFF_FFFF;
    endtask

    task automatic put_cnt(input int n, input logic [3:0] v);
        stat[n / 4][(3 - (n % 4)) * 8 +: 4] = v;
    endtask

    task automatic mem_erase();
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'hFFFF_FFFF;
    endtask

    // Launch a scan, optionally inject a second start mid-run, wait for done.
    task automatic run(input int page, input int cfg, input logic wide, input logic intrude);
        int m0;
        int s0;
        int t0;
        bit seen;
        m0 = mem_reads;
        s0 = stat_reads;
        @(negedge clk);
        page_num = PAGE_W'(page);
        page_cfg = 2'(cfg);
        wide_ecc = wide;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (intrude) begin
            @(negedge clk);
            @(negedge clk);
            page_num = '0;
            page_cfg = 2'd0;
            start    = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        seen = 0;
        for (int i = 0; i < 20000 && !seen; i++) begin
            if (done) seen = 1;
            else @(negedge clk);
        end
        check("R11 done seen", int'(seen), 1);
        got_total  = int'(corr_total);
        got_unc    = int'(uncorr);
        got_mreads = mem_reads - m0;
        got_sreads = stat_reads - s0;
        t0 = got_total;
        @(negedge clk);
        check("R11 done one cycle", int'(done), 0);
        repeat (3) @(negedge clk);
        check("R11 total held", int'(corr_total), t0);
    endtask

    task automatic t_reset();
        check("R1 done", int'(done), 0);
        check("R1 total", int'(corr_total), 0);
        check("R1 uncorr", int'(uncorr), 0);
    endtask

    task automatic t_small_page();
        stat_all_uncorr();
        stat[0][7:0] = 8'hA9;
        mem_erase();
        run(32'h13, 0, 1'b0, 1'b0);
        check("R3 small page count", got_total, 9);
        check("R2 small page uncorr", got_unc, 0);
        check("R2 small page status reads", got_sreads, 1);
    endtask

    task automatic t_mid_page();
        stat_all_uncorr();
        put_cnt(8, 4'd2);
        put_cnt(9, 4'd0);
        put_cnt(10, 4'd14);
        put_cnt(11, 4'd1);
        run(6, 1, 1'b0, 1'b0);
        check("R4 mid page total", got_total, 17);
        check("R2 mid page status reads", got_sreads, 4);
        check("R2 mid page uncorr", got_unc, 0);
    endtask

    task automatic t_large_page();
        stat_all_uncorr();
        for (int s = 8; s < 16; s++) put_cnt(s, 4'(s - 7));
        run(5, 2, 1'b0, 1'b0);
        check("R2 large page total", got_total, 36);
        check("R2 large page status reads", got_sreads, 8);
        run(5, 3, 1'b0, 1'b0);
        check("R2 code 3 as large page", got_total, 36);
    endtask

    task automatic t_saturate();
        stat_all_uncorr();
        for (int s = 0; s < 8; s++) put_cnt(s, 4'd14);
        run(0, 2, 1'b0, 1'b0);
        check("R5 saturated total", got_total, 63);
    endtask

    task automatic t_uncorr_dirty();
        stat_all_uncorr();
        put_cnt(0, 4'd3);
        put_cnt(1, 4'd15);
        put_cnt(2, 4'd5);
        put_cnt(3, 4'd5);
        mem_erase();
        mem[0] = 32'h0000_0000;
        run(0, 1, 1'b0, 1'b0);
        check("R6 total before stop", got_total, 3);
        check("R6 status reads stop", got_sreads, 2);
        check("R7 dirty page flagged", got_unc, 1);
        check("R10 one buffer read", got_mreads, 1);
    endtask

    task automatic t_clear_next();
        stat_all_uncorr();
        put_cnt(0, 4'd15);
        mem_erase();
        mem[3] = 32'h1234_5678;
        run(0, 1, 1'b0, 1'b0);
        check("R7 flag before clear", got_unc, 1);
        stat_all_uncorr();
        put_cnt(8, 4'd4);
        put_cnt(9, 4'd4);
        put_cnt(10, 4'd4);
        put_cnt(11, 4'd4);
        run(2, 1, 1'b0, 1'b0);
        check("R11 flag cleared by start", got_unc, 0);
        check("R11 total restarted", got_total, 16);
    endtask

    task automatic t_uncorr_blank();
        stat_all_uncorr();
        put_cnt(4, 4'd2);
        put_cnt(5, 4'd15);
        mem_erase();
        run(1, 1, 1'b0, 1'b0);
        check("R8 erased page not flagged", got_unc, 0);
        check("R8 total kept", got_total, 2);
        check("R7 full region read", got_mreads, 520);
    endtask

    task automatic t_spare_and_wide();
        stat_all_uncorr();
        put_cnt(4, 4'd15);
        mem_erase();
        mem[1024 + 512]     = 32'h0000_00FF;
        mem[1024 + 512 + 1] = 32'hFF00_FFFF;
        mem[1024 + 522]     = 32'hFFFF_FF00;
        run(1, 1, 1'b0, 1'b0);
        check("R9 spare outside narrow ECC ignored", got_unc, 0);
        check("R9 narrow region length", got_mreads, 520);
        run(1, 1, 1'b1, 1'b0);
        check("R7 wide ECC word flagged", got_unc, 1);
        check("R10 wide stop at dirty word", got_mreads, 521);
    endtask

    task automatic t_last_main();
        stat_all_uncorr();
        put_cnt(1, 4'd15);
        mem_erase();
        mem[127 + 256] = 32'h7FFF_FFFF;
        run(1, 0, 1'b0, 1'b0);
        check("R7 last main word flagged", got_unc, 1);
        check("R10 stop at last main word", got_mreads, 128);
    endtask

    task automatic t_busy_start();
        stat_all_uncorr();
        for (int s = 8; s < 16; s++) put_cnt(s, 4'(s - 7));
        put_cnt(0, 4'd1);
        run(5, 2, 1'b0, 1'b1);
        check("R12 restart ignored total", got_total, 36);
        check("R12 restart ignored reads", got_sreads, 8);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        stat_all_uncorr();
        mem_erase();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_small_page();
        t_mid_page();
        t_large_page();
        t_saturate();
        t_uncorr_dirty();
        t_clear_next();
        t_uncorr_blank();
        t_spare_and_wide();
        t_last_main();
        t_busy_start();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule